// File: doc/BRIEF.md
# Command Queue with Drain Watermark

This block is a sixteen-deep queue of command words placed between a host that writes commands and a graphics engine that takes them one at a time. The host presents a word with a push strobe. The engine sees the oldest stored word together with a valid signal, and it removes that word with a pop strobe. The block reports a live occupancy count from 0 to 16.

Software programs a drain watermark N. When the consumer lowers occupancy from exactly N to N-1, the block produces a one-cycle interrupt request and sets a sticky level flag, which stays set until software clears it. A watermark of zero turns this reporting off. A watermark above the queue depth is reserved and never triggers.

A module enable gates the whole block. While the enable is low, the queue is held empty. A stop-in-idle control works with an idle input: when both are high, the queue freezes in its current state. The width of a command word is a parameter.

Top module: `cmdq_wm_top`

## Requirements
- R1: `occ_o` reports the number of stored words, from 0 to 16, as a 5-bit binary value. It changes on the clock edge that accepts a push or a pop. `head_vld_o` is 1 exactly when `occ_o` is non-zero.
- R2: A push that arrives while 16 words are stored, with no pop in the same cycle, is discarded. Occupancy and the stored words do not change.
- R3: Words leave in the order they were accepted. `head_o` shows the oldest stored word whenever `head_vld_o` is 1.
- R4: Let `wmark_i` be N, with N from 1 to 16. A pop without a push that takes occupancy from N to N-1 raises `irq_o` for exactly one cycle. It also sets `lvl_o`. Both changes happen on the same edge as the occupancy update. No other transition raises `irq_o`.
- R5: A `wmark_i` value of 0 never raises `irq_o` and never sets `lvl_o`.
- R6: A `wmark_i` value from 17 to 31 never raises `irq_o` and never sets `lvl_o`.
- R7: `lvl_o` stays at 1 until a cycle with `lvl_clr_i` high clears it. If a trigger and a clear arrive in the same cycle, the flag ends up set.
- R8: A push and a pop accepted in the same cycle leave occupancy unchanged. They never raise `irq_o`.
- R9: A pop while the queue is empty is ignored. Occupancy stays at 0 and `head_vld_o` stays at 0.
- R10: While `en_i` is 0, the queue becomes empty on the next edge and pushes are ignored. `lvl_o` is cleared and `irq_o` stays at 0.
- R11: When `idle_stop_i` and `idle_i` are both 1, pushes and pops are ignored, and occupancy, the stored words and `lvl_o` hold their values. `idle_i` has no effect while `idle_stop_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Module enable |
| idle_stop_i | input | 1 | Freeze the block while idle |
| idle_i | input | 1 | Idle indication |
| wmark_i | input | 5 | Drain watermark, 0 = off, 17 to 31 reserved |
| push_i | input | 1 | Push strobe |
| push_data_i | input | CMD_W | Command word to store |
| pop_i | input | 1 | Pop strobe |
| head_vld_o | output | 1 | Queue holds at least one word |
| head_o | output | CMD_W | Oldest stored word |
| occ_o | output | 5 | Occupancy, 0 to 16 |
| lvl_o | output | 1 | Sticky watermark level flag |
| lvl_clr_i | input | 1 | Clear the level flag |
| irq_o | output | 1 | One-cycle watermark interrupt request |

## Verification
A wrong pointer or a wrong count first shows up as a wrong `head_o` word or a wrong `occ_o` on the edge after the faulty push or pop. It stays wrong from then on, so draining the queue exposes it within 16 pops. A wrong comparison in the watermark detector shows as an `irq_o` pulse on the wrong pop, or a missing one. The bench checks `irq_o` after every single pop through the threshold, at the watermark limits 0, 16 and 20, and during pops that coincide with pushes. Faults in the enable and idle gating show within one cycle as occupancy that moves or fails to clear.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  // Does the requested watermark select a trigger level inside the queue depth?
  function automatic logic wm_armed(input logic [7:0] wm, input int depth);
    return (wm != 8'd0) && (int'(wm) <= depth);
  endfunction
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int DEPTH = 16,
  parameter int CMD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CMD_W-1:0] rd_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CMD_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
    end
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/cmdq_count.sv
module cmdq_count #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          run,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] occ,
  output logic          nonempty
);
  logic full, empty;

  assign empty    = (occ == '0);
  assign full     = (int'(occ) == DEPTH);
  assign pop_ok   = run && pop_req && !empty;
  assign push_ok  = run && push_req && (!full || pop_ok);
  assign nonempty = !empty;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      occ <= '0;
    end else if (push_ok && !pop_ok) begin
      occ <= occ + 1'b1;
    end else if (pop_ok && !push_ok) begin
      occ <= occ - 1'b1;
    end
  end
endmodule

// File: rtl/cmdq_wm_detect.sv
module cmdq_wm_detect #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [CW-1:0] occ,
  input  logic [CW-1:0] wmark,
  input  logic          clr,
  output logic          irq,
  output logic          lvl
);
  import cmdq_pkg::*;

  logic hit;

  assign hit = pop_ok && !push_ok && (occ == wmark)
               && wm_armed(8'(wmark), DEPTH);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      irq <= 1'b0;
      lvl <= 1'b0;
    end else begin
      irq <= hit;
      if (hit)      lvl <= 1'b1;
      else if (clr) lvl <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdq_wm_top.sv
module cmdq_wm_top #(
  parameter int DEPTH = 16,
  parameter int CMD_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             idle_stop_i,
  input  logic             idle_i,
  input  logic [CW-1:0]    wmark_i,
  input  logic             push_i,
  input  logic [CMD_W-1:0] push_data_i,
  input  logic             pop_i,
  output logic             head_vld_o,
  output logic [CMD_W-1:0] head_o,
  output logic [CW-1:0]    occ_o,
  output logic             lvl_o,
  input  logic             lvl_clr_i,
  output logic             irq_o
);
  logic flush, run, push_ok, pop_ok, nonempty;

  assign flush = !en_i;
  assign run   = en_i && !(idle_stop_i && idle_i);

  cmdq_count #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst(rst), .flush(flush), .run(run),
    .push_req(push_i), .pop_req(pop_i),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .occ(occ_o), .nonempty(nonempty)
  );

  cmdq_store #(.DEPTH(DEPTH), .CMD_W(CMD_W)) u_mem (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(push_ok), .wr_data(push_data_i),
    .rd_en(pop_ok), .rd_data(head_o)
  );

  cmdq_wm_detect #(.DEPTH(DEPTH)) u_wm (
    .clk(clk), .rst(rst), .flush(flush),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .occ(occ_o), .wmark(wmark_i), .clr(lvl_clr_i & run),
    .irq(irq_o), .lvl(lvl_o)
  );

  assign head_vld_o = nonempty;
endmodule

// File: rtl/cmdq_wm_chk.sv
module cmdq_wm_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          en_i,
  input logic          idle_stop_i,
  input logic          idle_i,
  input logic [CW-1:0] wmark_i,
  input logic          push_i,
  input logic          pop_i,
  input logic          head_vld_o,
  input logic [CW-1:0] occ_o,
  input logic          lvl_o,
  input logic          irq_o
);
  // R1
  occ_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(occ_o) <= DEPTH);
  // R1
  vld_match_chk: assert property (@(posedge clk) disable iff (rst)
    head_vld_o == (occ_o != '0));
  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && int'(occ_o) == DEPTH && !pop_i) |=> int'(occ_o) == DEPTH);
  // R4
  irq_step_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(occ_o) == $past(wmark_i)) && (occ_o == $past(occ_o) - 1'b1));
  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R5
  wm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(wmark_i) != '0);
  // R6
  wm_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> int'($past(wmark_i)) <= DEPTH);
  // R7
  lvl_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_o) |-> irq_o);
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (occ_o == '0 && !push_i) |=> occ_o == '0);
  // R10
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (occ_o == '0) && !lvl_o && !irq_o);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && idle_stop_i && idle_i) |=> $stable(occ_o) && !irq_o);
endmodule

bind cmdq_wm_top cmdq_wm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .idle_stop_i(idle_stop_i), .idle_i(idle_i),
  .wmark_i(wmark_i), .push_i(push_i), .pop_i(pop_i), .head_vld_o(head_vld_o),
  .occ_o(occ_o), .lvl_o(lvl_o), .irq_o(irq_o)
);

// File: tb/sim_cmdq_wm_top.sv
`timescale 1ns/1ps
module sim_cmdq_wm_top;
  localparam int DEPTH = 16;
  localparam int CMD_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, istop = 1'b0, idle = 1'b0;
  logic [4:0] wm = '0;
  logic push = 1'b0, pop = 1'b0, clr = 1'b0;
  logic [CMD_W-1:0] din = '0;
  logic vld, lvl, irq;
  logic [CMD_W-1:0] head;
  logic [4:0] occ;

  int checks = 0, fails = 0, cyc_n = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmdq_wm_top #(.DEPTH(DEPTH), .CMD_W(CMD_W)) u0 (
    .clk(clk), .rst(rst), .en_i(en), .idle_stop_i(istop), .idle_i(idle),
    .wmark_i(wm), .push_i(push), .push_data_i(din), .pop_i(pop),
    .head_vld_o(vld), .head_o(head), .occ_o(occ), .lvl_o(lvl),
    .lvl_clr_i(clr), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, let one rising edge pass, then sample 1 ns later.
  task automatic step(input logic p, input logic q, input logic [CMD_W-1:0] d);
    @(negedge clk);
    push = p; pop = q; din = d;
    @(posedge clk); #1;
    push = 0; pop = 0; clr = 0;
  endtask

  task automatic restart();
    @(negedge clk);
    rst = 1; en = 1; istop = 0; idle = 0; wm = 0; clr = 0;
    @(posedge clk); #1;
    rst = 0;
  endtask

  task automatic fill(input int n, input int base);
    for (int i = 0; i < n; i++) step(1, 0, CMD_W'(base + i));
  endtask

  task automatic t_reset();
    restart();
    check("R1 reset occ", occ, 0);
    check("R1 reset vld", vld, 0);
    check("R4 reset irq", irq, 0);
    check("R7 reset lvl", lvl, 0);
  endtask

  task automatic t_full_order();
    restart();
    fill(3, 16'h100);
    check("R1 occ after 3 pushes", occ, 3);
    check("R1 vld nonempty", vld, 1);
    fill(13, 16'h103);
    check("R1 occ full", occ, 16);
    step(1, 0, 16'hDEAD);
    check("R2 full push dropped occ", occ, 16);
    for (int i = 0; i < 16; i++) begin
      check("R3 head order", head, 16'h100 + i);
      step(0, 1, 0);
    end
    check("R2 dropped word absent occ", occ, 0);
    check("R1 vld empty", vld, 0);
  endtask

  task automatic t_watermark(input int n, input int fillc, input string req);
    restart();
    wm = 5'(n);
    fill(fillc, 0);
    for (int k = fillc; k > 0; k--) begin
      step(0, 1, 0);
      check({req, " irq on pop"}, irq, (k == n) ? 1 : 0);
      check({req, " lvl sticky"}, lvl, (k <= n && n >= 1 && n <= 16) ? 1 : 0);
    end
  endtask

  task automatic t_clear();
    restart();
    wm = 5'd2;
    fill(3, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    check("R4 irq 2->1", irq, 1);
    step(0, 0, 0);
    check("R4 irq one cycle", irq, 0);
    check("R7 lvl held", lvl, 1);
    @(negedge clk); clr = 1;
    step(0, 0, 0);
    check("R7 lvl cleared", lvl, 0);
    fill(1, 0);
    @(negedge clk); clr = 1;
    step(0, 1, 0);
    check("R7 set beats clear", lvl, 1);
  endtask

  task automatic t_pushpop();
    restart();
    wm = 5'd4;
    fill(4, 16'h40);
    step(1, 1, 16'h44);
    check("R8 occ unchanged", occ, 4);
    check("R8 no irq", irq, 0);
    check("R3 head after push+pop", head, 16'h41);
    fill(12, 16'h50);
    step(1, 1, 16'h77);
    check("R8 full push+pop occ", occ, 16);
  endtask

  task automatic t_empty_pop();
    restart();
    step(0, 1, 0);
    check("R9 empty pop occ", occ, 0);
    check("R9 empty pop vld", vld, 0);
    step(1, 0, 16'hABCD);
    check("R9 later push head", head, 16'hABCD);
  endtask

  task automatic t_disable();
    restart();
    wm = 5'd3;
    fill(3, 0);
    step(0, 1, 0);
    check("R10 setup lvl", lvl, 1);
    @(negedge clk); en = 0;
    step(1, 0, 16'h9);
    check("R10 flushed occ", occ, 0);
    check("R10 lvl cleared", lvl, 0);
    step(1, 0, 16'h9);
    check("R10 push ignored", occ, 0);
    @(negedge clk); en = 1;
    step(1, 0, 16'h31);
    check("R10 restart head", head, 16'h31);
  endtask

  task automatic t_idle();
    restart();
    wm = 5'd2;
    fill(2, 16'h60);
    @(negedge clk); istop = 1; idle = 1;
    step(1, 0, 16'h1);
    check("R11 push frozen", occ, 2);
    step(0, 1, 0);
    check("R11 pop frozen", occ, 2);
    check("R11 no irq frozen", irq, 0);
    check("R11 head held", head, 16'h60);
    @(negedge clk); istop = 0;
    step(0, 1, 0);
    check("R11 idle alone no effect", occ, 1);
    check("R11 irq after unfreeze", irq, 1);
  endtask

  initial begin
    t_reset();
    t_full_order();
    t_watermark(5, 8, "R4 wm5");
    t_watermark(16, 16, "R4 wm16");
    t_watermark(0, 6, "R5 wm0");
    t_watermark(20, 16, "R6 wm20");
    t_clear();
    t_pushpop();
    t_empty_pop();
    t_disable();
    t_idle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule